// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

The controller gathers 32 level-sensitive request lines into one maskable request with a vector number and one separate non-maskable request. Lines 1 through 29 are copied each clock into a raw pending word. Software writes an enable word, and the pending bits that survive it are encoded into a vector for the core.

A lone surviving source i yields vector 0x31 + i. When two or more survive, the controller gives the shared vector 0x30, and software reads the masked word to choose among them. Lines 30 and 31 feed a non-maskable status word and its own request output, and the enable word does not gate them. Line 0 is not used.

The encoder is a three-state machine whose state is the class of the next masked word. ENC_QUIET means no source survives the mask. ENC_SINGLE means exactly one source survives, and the state keeps its index. ENC_SHARED means two or more survive. On every clock the machine moves to whichever state the incoming masked word calls for. Every state can reach every other in one clock: QUIET to SINGLE when one source arrives, SINGLE to SHARED when a second joins, SHARED to SINGLE or QUIET as sources drop, and so on. It stays in a state while the class does not change.

Top module: `vic_core`

## Requirements
- R1: A synchronous active-high reset clears every output and register to zero: the enable word, the raw word, the non-maskable word, the read data, the vector, and both requests.
- R2: A full write (byte enables 4'hF, address bits [1:0] zero) to byte offset 0x0 loads the enable word at the clock edge. Full writes to any other offset change no register.
- R3: An access with byte enables other than 4'hF, or with nonzero address bits [1:0], is ignored. Such a write changes nothing, and such a read returns zero.
- R4: Each line n from 1 to 29 drives bit n-1 of the raw word, readable at offset 0x4. The bit is 1 while the line is high and 0 while it is low, and it follows the line one clock later. Raw bits 29 to 31 are always 0.
- R5: The word at offset 0x8 always equals the raw word ANDed with the enable word.
- R6: One clock after an input or enable change, the vector reflects the masked word. It is 0 when the masked word is zero, 0x31 + i when only bit i is set, and 0x30 when more than one bit is set.
- R7: The maskable request output is high exactly when the vector is nonzero.
- R8: Lines 30 and 31 set bits 30 and 31 of the non-maskable word at offset 0xC according to their level, one clock later. They never touch the raw word. The non-maskable request is high whenever that word is nonzero, regardless of the enable word.
- R9: Line 0 has no effect on any register or output.
- R10: The diagnostic word at offset 0x10 reads zero, as does any offset above 0x10.
- R11: A read strobe sampled at a clock edge loads the read data with the register value held before that edge. The read data is visible after that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive request lines |
| bus_addr | input | 5 | Byte address of the register access |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Maskable interrupt request |
| irq_vec | output | 8 | Vector number for the core |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The assertions watch several things on every cycle. The maskable request must agree with the vector. A nonzero vector must lie in the legal range. The vector must be zero whenever lines 1 to 29 were all low on the previous clock. The non-maskable request must track lines 30 and 31 with one clock of delay, and the clock after reset must leave every output at zero.

Other behaviour depends on the enable word and the bus, so only the bench scenarios can show it. That covers the choice between the single and shared vectors, the exact single-source vector number, the ignored writes at other offsets and with partial enables, line 0 having no effect, and the read-back values.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        ENC_QUIET  = 2'd0,
        ENC_SINGLE = 2'd1,
        ENC_SHARED = 2'd2
    } enc_state_t;

    localparam logic [7:0] SHARED_VEC = 8'h30;
    localparam logic [7:0] BASE_VEC   = 8'h31;

    localparam int IDX_ENABLE = 0;
    localparam int IDX_RAW    = 1;
    localparam int IDX_MASKED = 2;
    localparam int IDX_NMI    = 3;
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int NMI_LO = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] lines,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W/8-1:0] be,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NMI_LO-2:0] masked_next,
    output logic              nmi_any
);
    import vic_pkg::*;

    localparam int SRC_W = NMI_LO - 1;
    localparam int IDX_W = ADDR_W - 2;

    logic [DATA_W-1:0] enable_q, raw_q, nmi_q;
    logic [DATA_W-1:0] enable_d, raw_d, nmi_d, rd_mux;
    logic              full_acc;
    logic [IDX_W-1:0]  widx;

    // Lines 1..SRC_W map onto raw bits 0..SRC_W-1; line 0 is dropped.
    for (genvar g = 0; g < DATA_W; g++) begin : g_map
        if (g < SRC_W) begin : g_src
            assign raw_d[g] = lines[g+1];
        end else begin : g_nosrc
            assign raw_d[g] = 1'b0;
        end
        if (g >= NMI_LO) begin : g_nmi
            assign nmi_d[g] = lines[g];
        end else begin : g_nonmi
            assign nmi_d[g] = 1'b0;
        end
    end

    always_comb begin
        full_acc = (be == '1) && (addr[1:0] == 2'b00);
        widx     = addr[ADDR_W-1:2];
        enable_d = enable_q;
        if (wr && full_acc && (int'(widx) == IDX_ENABLE)) begin
            enable_d = wdata;
        end
        rd_mux = '0;
        if (full_acc) begin
            unique case (int'(widx))
                IDX_ENABLE: rd_mux = enable_q;
                IDX_RAW:    rd_mux = raw_q;
                IDX_MASKED: rd_mux = raw_q & enable_q;
                IDX_NMI:    rd_mux = nmi_q;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            raw_q    <= '0;
            nmi_q    <= '0;
            rdata    <= '0;
        end else begin
            enable_q <= enable_d;
            raw_q    <= raw_d;
            nmi_q    <= nmi_d;
            if (rd) begin
                rdata <= rd_mux;
            end
        end
    end

    logic [DATA_W-1:0] masked_full;
    assign masked_full = raw_d & enable_d;
    assign masked_next = masked_full[SRC_W-1:0];
    assign nmi_any     = |nmi_q;
endmodule

// File: rtl/vic_encoder.sv
module vic_encoder #(
    parameter int SRC_W = 29,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_next,
    output logic [VEC_W-1:0] vec,
    output logic             req
);
    import vic_pkg::*;

    localparam int IDX_W = $clog2(SRC_W);

    enc_state_t       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             found, multi;

    always_comb begin
        idx_n = idx_q;
        found = 1'b0;
        for (int i = 0; i < SRC_W; i++) begin
            if (src_next[i] && !found) begin
                idx_n = IDX_W'(i);
                found = 1'b1;
            end
        end
        multi = |(src_next & (src_next - SRC_W'(1)));
        if (!found)     state_n = ENC_QUIET;
        else if (multi) state_n = ENC_SHARED;
        else            state_n = ENC_SINGLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENC_QUIET;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    always_comb begin
        unique case (state_q)
            ENC_QUIET:  vec = '0;
            ENC_SINGLE: vec = VEC_W'(BASE_VEC) + VEC_W'(idx_q);
            ENC_SHARED: vec = VEC_W'(SHARED_VEC);
            default:    vec = '0;
        endcase
        req = (state_q != ENC_QUIET);
    end
endmodule

// File: rtl/vic_core.sv
module vic_core #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int VEC_W  = 8,
    parameter int NMI_LO = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              nmi_req
);
    localparam int SRC_W = NMI_LO - 1;

    logic [SRC_W-1:0] masked_next;

    vic_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NMI_LO(NMI_LO)) u_regs (
        .clk(clk), .rst(rst), .lines(irq_in), .addr(bus_addr), .be(bus_be),
        .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata), .rdata(bus_rdata),
        .masked_next(masked_next), .nmi_any(nmi_req)
    );

    vic_encoder #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_enc (
        .clk(clk), .rst(rst), .src_next(masked_next), .vec(irq_vec), .req(irq_req)
    );
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] irq_in,
    input logic [31:0] bus_rdata,
    input logic        irq_req,
    input logic [7:0]  irq_vec,
    input logic        nmi_req
);
    p_req_agrees_vec_r7: assert property (@(posedge clk) disable iff (rst)
        irq_req == (irq_vec != 8'h00));

    p_vec_legal_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_vec == 8'h00) || ((irq_vec >= 8'h30) && (irq_vec <= 8'h4D)));

    p_quiet_lines_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(irq_in[29:1]) == 29'd0)) |-> (irq_vec == 8'h00));

    p_nmi_tracks_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (nmi_req == ($past(irq_in[31:30]) != 2'b00)));

    p_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_vec == 8'h00 && !irq_req && !nmi_req && bus_rdata == 32'h0));
endmodule

bind vic_core vic_checker u_chk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req)
);

// File: tb/sim_vic_core.sv
module sim_vic_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic        nmi_req;

    always #4 clk = ~clk;

    vic_core u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    logic [31:0] m_en = '0, m_raw = '0, m_nmi = '0, m_rd = '0;

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] a, input logic [3:0] b);
        if (b != 4'hF || a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0:    return m_en;
            3'd1:    return m_raw;
            3'd2:    return m_raw & m_en;
            3'd3:    return m_nmi;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] model_vec();
        logic [31:0] mv = m_raw & m_en;
        if (mv == 0) return 8'h00;
        if ($countones(mv) > 1) return 8'h30;
        for (int i = 0; i < 32; i++) if (mv[i]) return 8'h31 + 8'(i);
        return 8'h00;
    endfunction

    task automatic cycle();
        @(posedge clk);
        if (rst) begin
            m_en = '0; m_raw = '0; m_nmi = '0; m_rd = '0;
        end else begin
            if (bus_rd) m_rd = model_read(bus_addr, bus_be);
            if (bus_wr && bus_be == 4'hF && bus_addr == 5'h00) m_en = bus_wdata;
            m_raw = '0;
            for (int n = 1; n <= 29; n++) m_raw[n-1] = irq_in[n];
            m_nmi = {irq_in[31:30], 30'h0};
        end
        @(negedge clk);
        chk({tag, " vec"}, {24'h0, irq_vec}, {24'h0, model_vec()});
        chk({tag, " irq_req R7"}, {31'h0, irq_req}, {31'h0, (model_vec() != 0)});
        chk({tag, " nmi_req"}, {31'h0, nmi_req}, {31'h0, (m_nmi != 0)});
        chk({tag, " rdata"}, bus_rdata, m_rd);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
        bus_addr = a; bus_wdata = d; bus_be = b; bus_wr = 1'b1;
        cycle();
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [3:0] b, input logic [31:0] exp, input string t);
        bus_addr = a; bus_be = b; bus_rd = 1'b1;
        cycle();
        bus_rd = 1'b0; bus_be = 4'hF;
        chk(t, bus_rdata, exp);
    endtask

    task automatic lines(input logic [31:0] v);
        irq_in = v;
        cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tag = "R1";
        irq_in = 32'hFFFF_FFFF;
        cycle(); cycle();
        rst = 1'b0; irq_in = '0;
        cycle();
        rd_reg(5'h00, 4'hF, 32'h0, "R1 enable after reset");

        tag = "R2";
        wr_reg(5'h00, 32'hFFFF_FFFF, 4'hF);
        rd_reg(5'h00, 4'hF, 32'hFFFF_FFFF, "R2 enable readback");

        tag = "R4";
        lines(32'h0000_0020);
        rd_reg(5'h04, 4'hF, 32'h0000_0010, "R4 raw line5");
        tag = "R6";
        chk("R6 single vec line5", {24'h0, irq_vec}, 32'h35);
        lines(32'h0000_0220);
        chk("R6 shared vec", {24'h0, irq_vec}, 32'h30);
        lines(32'h2000_0000);
        chk("R6 top source vec", {24'h0, irq_vec}, 32'h4D);
        lines(32'h0000_0000);
        chk("R6 quiet vec", {24'h0, irq_vec}, 32'h00);
        chk("R7 quiet req", {31'h0, irq_req}, 32'h0);

        tag = "R5";
        lines(32'h0000_0220);
        wr_reg(5'h00, 32'h0000_0010, 4'hF);
        chk("R5 mask narrows to single", {24'h0, irq_vec}, 32'h35);
        rd_reg(5'h08, 4'hF, 32'h0000_0010, "R5 masked word");

        tag = "R2";
        wr_reg(5'h04, 32'hFFFF_FFFF, 4'hF);
        wr_reg(5'h08, 32'hFFFF_FFFF, 4'hF);
        wr_reg(5'h10, 32'hFFFF_FFFF, 4'hF);
        rd_reg(5'h00, 4'hF, 32'h0000_0010, "R2 other offsets ignored");
        rd_reg(5'h04, 4'hF, 32'h0000_0110, "R2 raw untouched by write");

        tag = "R3";
        wr_reg(5'h00, 32'hFFFF_FFFF, 4'h3);
        wr_reg(5'h02, 32'hFFFF_FFFF, 4'hF);
        rd_reg(5'h00, 4'hF, 32'h0000_0010, "R3 partial write ignored");
        rd_reg(5'h00, 4'h1, 32'h0, "R3 partial read zero");
        rd_reg(5'h01, 4'hF, 32'h0, "R3 misaligned read zero");

        tag = "R8";
        wr_reg(5'h00, 32'h0, 4'hF);
        lines(32'h4000_0000);
        chk("R8 nmi ungated", {31'h0, nmi_req}, 32'h1);
        rd_reg(5'h0C, 4'hF, 32'h4000_0000, "R8 nmi word");
        rd_reg(5'h04, 4'hF, 32'h0, "R8 raw untouched");
        wr_reg(5'h00, 32'hFFFF_FFFF, 4'hF);
        lines(32'h8000_0000);
        chk("R8 no vector from nmi line", {24'h0, irq_vec}, 32'h0);
        lines(32'h0);
        chk("R8 nmi clears", {31'h0, nmi_req}, 32'h0);

        tag = "R9";
        lines(32'h0000_0001);
        chk("R9 line0 no vec", {24'h0, irq_vec}, 32'h0);
        rd_reg(5'h04, 4'hF, 32'h0, "R9 raw zero");
        rd_reg(5'h0C, 4'hF, 32'h0, "R9 nmi zero");

        tag = "R10";
        lines(32'hFFFF_FFFF);
        rd_reg(5'h10, 4'hF, 32'h0, "R10 diag zero");
        rd_reg(5'h14, 4'hF, 32'h0, "R10 above diag zero");
        rd_reg(5'h1C, 4'hF, 32'h0, "R10 top offset zero");

        tag = "R11";
        rd_reg(5'h04, 4'hF, 32'h1FFF_FFFF, "R11 raw all lines");
        lines(32'h0);
        chk("R11 rdata holds without strobe", bus_rdata, 32'h1FFF_FFFF);
        irq_in = 32'h0000_0008;
        rd_reg(5'h04, 4'hF, 32'h0, "R11 read sees pre-edge value");

        tag = "R1";
        rst = 1'b1;
        cycle();
        rst = 1'b0;
        rd_reg(5'h00, 4'hF, 32'h0, "R1 enable cleared by reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule